// File: doc/BRIEF.md
# Mode-Gated Miscellaneous Register Bank

This block is a small register file of eight byte-wide locations on a simple offset/write-strobe bus. It holds an infrared port control register, five spare scratch registers and two read-only mirrors of four 4-bit audio channel amplitudes. Reads are combinational from the offset. Writes take effect at the clock edge when the strobe is high.

A color-mode input decides whether some registers can be written and what they read back. When the input is low, the chip is in compatibility mode. In that mode two of the spare registers read as all-ones and ignore writes. Stored contents are kept while the mode is changed, because the mode only gates the read view and write acceptance.

Each register has its own mask of writable bits and its own reset value. Bits that cannot be written always read as 1. The infrared receive input is taken through a two-flop synchroniser. Its value is shown only while the receive enable field is fully set.

Top module: `misc_regbank`

## Requirements
- R1: After reset, with color mode high, the registers read as follows: offset 0x00 reads 0x3E, 0x01 reads 0xFE, 0x02 reads 0x00, 0x03 reads 0x00, 0x04 reads 0x00 and 0x05 reads 0x8F.
- R2: IR register (offset 0x00): bit 0 is read/write and drives `ir_led` directly (1 = LED on). Bits 7:6 are a read/write receive-enable field. Bits 5:2 read as 1.
- R3: IR register bit 1 is read-only. When bits 7:6 equal 2'b11, bit 1 shows `ir_rx`, delayed by two clock edges (0 = signal being received). Otherwise bit 1 reads 1.
- R4: Offset 0x01: only bit 0 is writable, and only in color mode. Its other bits read 1. In compatibility mode this register reads 0xFF and ignores writes.
- R5: Offsets 0x02 and 0x03 are fully read/write in both modes. A written byte reads back unchanged.
- R6: Offset 0x04 is fully read/write in color mode. In compatibility mode it reads 0xFF and ignores writes.
- R7: Offset 0x05: only bits 6:4 are writable, and they reset to 0. Bits 7 and 3:0 read 1.
- R8: Offset 0x06 reads {amp2, amp1} and offset 0x07 reads {amp4, amp3}, where the low nibble is the lower-numbered channel. Writes to these offsets have no effect.
- R9: Register contents survive a change of `color_mode`. A value written in color mode reads back again after a trip through compatibility mode.
- R10: Offsets 0x08 to 0xFF read 0xFF, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Register offset |
| wr_data | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, sampled at the rising clock edge |
| rd_data | output | 8 | Combinational read data for `addr` |
| color_mode | input | 1 | 1 = color mode, 0 = compatibility mode |
| ir_led | output | 1 | Infrared LED drive, 1 = on |
| ir_rx | input | 1 | Asynchronous infrared receive level, 0 = receiving |
| amp1 | input | 4 | Channel 1 amplitude |
| amp2 | input | 4 | Channel 2 amplitude |
| amp3 | input | 4 | Channel 3 amplitude |
| amp4 | input | 4 | Channel 4 amplitude |

## Verification
The bench writes patterns to each register and reads them back, and it does this in both modes. A wrong write mask shows up here: a masked bit would stick at 0 or take a write it should refuse. Compatibility-mode writes to the gated registers are checked after the mode returns to color mode. A design that gated storage rather than only the view would lose the stored byte or take in the refused write. The receive bit is sampled one and two edges after `ir_rx` falls, which catches a synchroniser that is missing a stage or has an extra one. The bench also checks that the receive bit is forced to 1 while the enable field is only partly set. Writes to the amplitude mirrors and to unmapped offsets are read back to show that nothing was stored.

// File: rtl/misc_regbank_pkg.sv
package misc_regbank_pkg;
  localparam int DW      = 8;
  localparam int AW      = 8;
  localparam int NSPARE  = 5;

  localparam logic [AW-1:0] OFF_IR     = 8'h00;
  localparam logic [AW-1:0] OFF_AMP_LO = 8'h06;
  localparam logic [AW-1:0] OFF_AMP_HI = 8'h07;
  localparam logic [AW-1:0] OFF_LAST   = 8'h07;

  localparam logic [DW-1:0] IR_MASK = 8'hC1;
  localparam logic [DW-1:0] IR_RST  = 8'h00;
  localparam int            IR_RX_BIT = 1;

  typedef struct packed {
    logic [AW-1:0] off;
    logic [DW-1:0] mask;
    logic [DW-1:0] rst;
    logic          color_only;
  } spare_cfg_t;

  localparam spare_cfg_t SPARE_CFG [NSPARE] = '{
    '{off: 8'h01, mask: 8'h01, rst: 8'h00, color_only: 1'b1},
    '{off: 8'h02, mask: 8'hFF, rst: 8'h00, color_only: 1'b0},
    '{off: 8'h03, mask: 8'hFF, rst: 8'h00, color_only: 1'b0},
    '{off: 8'h04, mask: 8'hFF, rst: 8'h00, color_only: 1'b1},
    '{off: 8'h05, mask: 8'h70, rst: 8'h00, color_only: 1'b0}
  };

  // Keep held bits outside the mask, take new bits inside it.
  function automatic logic [DW-1:0] merge_write(input logic [DW-1:0] held,
                                                input logic [DW-1:0] wd,
                                                input logic [DW-1:0] mask);
    return (held & ~mask) | (wd & mask);
  endfunction

  // Bits outside the writable mask are presented as ones.
  function automatic logic [DW-1:0] present(input logic [DW-1:0] held,
                                            input logic [DW-1:0] mask);
    return (held & mask) | ~mask;
  endfunction
endpackage

// File: rtl/misc_rx_sync.sv
module misc_rx_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic stage1;
  logic stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= 1'b1;
      stage2 <= 1'b1;
    end else begin
      stage1 <= async_in;
      stage2 <= stage1;
    end
  end

  assign sync_out = stage2;
endmodule

// File: rtl/misc_reg_cell.sv
module misc_reg_cell
  import misc_regbank_pkg::*;
#(
  parameter logic [DW-1:0] MASK       = 8'hFF,
  parameter logic [DW-1:0] RST        = 8'h00,
  parameter bit            COLOR_ONLY = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          color_mode,
  input  logic          sel_wr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] held,
  output logic [DW-1:0] view
);
  logic          unlocked;
  logic          take;
  logic [DW-1:0] q;

  assign unlocked = !COLOR_ONLY || color_mode;
  assign take     = sel_wr && unlocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= RST & MASK;
    else if (take) q <= merge_write(q, wr_data, MASK);
  end

  assign held = q;
  assign view = unlocked ? present(q, MASK) : '1;
endmodule

// File: rtl/misc_regbank.sv
module misc_regbank
  import misc_regbank_pkg::*;
#(
  parameter int AMP_W = DW / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wr_data,
  input  logic             wr_en,
  output logic [DW-1:0]    rd_data,
  input  logic             color_mode,
  output logic             ir_led,
  input  logic             ir_rx,
  input  logic [AMP_W-1:0] amp1,
  input  logic [AMP_W-1:0] amp2,
  input  logic [AMP_W-1:0] amp3,
  input  logic [AMP_W-1:0] amp4
);
  logic [DW-1:0] ir_held;
  logic [DW-1:0] ir_base;
  logic [DW-1:0] ir_view;
  logic          ir_rx_enabled;
  logic          ir_rx_sync;
  logic          ir_wr_sel;
  logic [DW-1:0] spare_view [NSPARE];
  logic [DW-1:0] spare_held [NSPARE];
  logic [NSPARE-1:0] spare_wr_sel;

  assign ir_wr_sel = wr_en && (addr == OFF_IR);

  misc_reg_cell #(.MASK(IR_MASK), .RST(IR_RST), .COLOR_ONLY(1'b0)) u_ir_cell (
    .clk(clk), .rst_n(rst_n), .color_mode(color_mode), .sel_wr(ir_wr_sel),
    .wr_data(wr_data), .held(ir_held), .view(ir_base)
  );

  misc_rx_sync u_rx_sync (
    .clk(clk), .rst_n(rst_n), .async_in(ir_rx), .sync_out(ir_rx_sync)
  );

  assign ir_led        = ir_held[0];
  assign ir_rx_enabled = (ir_held[7:6] == 2'b11);

  always_comb begin
    ir_view = ir_base;
    ir_view[IR_RX_BIT] = ir_rx_enabled ? ir_rx_sync : 1'b1;
  end

  for (genvar gi = 0; gi < NSPARE; gi++) begin : g_spare
    assign spare_wr_sel[gi] = wr_en && (addr == SPARE_CFG[gi].off);
    misc_reg_cell #(
      .MASK(SPARE_CFG[gi].mask),
      .RST(SPARE_CFG[gi].rst),
      .COLOR_ONLY(SPARE_CFG[gi].color_only)
    ) u_cell (
      .clk(clk), .rst_n(rst_n), .color_mode(color_mode),
      .sel_wr(spare_wr_sel[gi]), .wr_data(wr_data),
      .held(spare_held[gi]), .view(spare_view[gi])
    );
  end

  always_comb begin
    rd_data = '1;
    if (addr == OFF_IR)     rd_data = ir_view;
    if (addr == OFF_AMP_LO) rd_data = {amp2, amp1};
    if (addr == OFF_AMP_HI) rd_data = {amp4, amp3};
    for (int i = 0; i < NSPARE; i++) begin
      if (addr == SPARE_CFG[i].off) rd_data = spare_view[i];
    end
  end
endmodule

// File: rtl/misc_regbank_chk.sv
module misc_regbank_chk
  import misc_regbank_pkg::*;
#(
  parameter int AMP_W = DW / 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    addr,
  input logic [DW-1:0]    wr_data,
  input logic             wr_en,
  input logic [DW-1:0]    rd_data,
  input logic             color_mode,
  input logic             ir_led,
  input logic [AMP_W-1:0] amp1,
  input logic [AMP_W-1:0] amp2,
  input logic [AMP_W-1:0] amp3,
  input logic [AMP_W-1:0] amp4
);
  assert_led_matches_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == OFF_IR) |-> (rd_data[0] == ir_led && rd_data[5:2] == 4'hF));

  assert_rx_bit_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == OFF_IR && rd_data[7:6] != 2'b11) |-> rd_data[1]);

  assert_locked_low_spare_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 8'h01) |-> (rd_data[7:1] == 7'h7F && (color_mode || rd_data[0])));

  assert_scratch_writeback_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 8'h02) |=> (addr != 8'h02 || rd_data == $past(wr_data)));

  assert_locked_full_spare_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 8'h04 && !color_mode) |-> (rd_data == 8'hFF));

  assert_partial_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 8'h05) |-> (rd_data[7] && rd_data[3:0] == 4'hF));

  assert_amp_mirror_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == OFF_AMP_LO) |-> (rd_data[3:0] == amp1 && rd_data[7:4] == amp2));

  assert_amp_mirror_hi_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == OFF_AMP_HI) |-> (rd_data[3:0] == amp3 && rd_data[7:4] == amp4));

  assert_unmapped_ones_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (addr > OFF_LAST) |-> (rd_data == 8'hFF));
endmodule

bind misc_regbank misc_regbank_chk #(.AMP_W(AMP_W)) u_misc_regbank_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data), .wr_en(wr_en),
  .rd_data(rd_data), .color_mode(color_mode), .ir_led(ir_led),
  .amp1(amp1), .amp2(amp2), .amp3(amp3), .amp4(amp4)
);

// File: tb/test_misc_regbank.sv
module test_misc_regbank;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wr_data = 8'h00;
  logic       wr_en = 1'b0;
  logic [7:0] rd_data;
  logic       color_mode = 1'b1;
  logic       ir_led;
  logic       ir_rx = 1'b1;
  logic [3:0] amp1 = 4'h0, amp2 = 4'h0, amp3 = 4'h0, amp4 = 4'h0;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  misc_regbank i_misc_regbank (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data), .wr_en(wr_en),
    .rd_data(rd_data), .color_mode(color_mode), .ir_led(ir_led), .ir_rx(ir_rx),
    .amp1(amp1), .amp2(amp2), .amp3(amp3), .amp4(amp4)
  );

  // {mode, offset, write byte, expected read, requirement number}
  localparam int NVEC = 13;
  localparam logic [28:0] VEC [NVEC] = '{
    {1'b1, 8'h01, 8'h00, 8'hFE, 4'd4},  // R4 bit 0 cleared
    {1'b1, 8'h01, 8'hFF, 8'hFF, 4'd4},  // R4 bit 0 set
    {1'b1, 8'h01, 8'h00, 8'hFE, 4'd4},
    {1'b1, 8'h02, 8'hA5, 8'hA5, 4'd5},  // R5
    {1'b0, 8'h02, 8'h5A, 8'h5A, 4'd5},
    {1'b1, 8'h03, 8'h3C, 8'h3C, 4'd5},
    {1'b0, 8'h03, 8'hC3, 8'hC3, 4'd5},
    {1'b1, 8'h04, 8'h96, 8'h96, 4'd6},  // R6
    {1'b1, 8'h05, 8'hFF, 8'hFF, 4'd7},  // R7
    {1'b1, 8'h05, 8'h00, 8'h8F, 4'd7},
    {1'b1, 8'h05, 8'hA5, 8'hAF, 4'd7},
    {1'b0, 8'h04, 8'h11, 8'hFF, 4'd6},  // R6 locked
    {1'b0, 8'h01, 8'h00, 8'hFF, 4'd4}   // R4 locked
  };

  task automatic write_reg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic check_rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    addr = a;
    #1;
    checks++;
    if (rd_data !== exp) begin
      fails++;
      $display("FAIL %s: offset %02h read %02h expected %02h", tag, a, rd_data, exp);
    end
  endtask

  task automatic check_bit(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_rd(8'h00, 8'h3E, "R1");
    check_rd(8'h01, 8'hFE, "R1");
    check_rd(8'h02, 8'h00, "R1");
    check_rd(8'h03, 8'h00, "R1");
    check_rd(8'h04, 8'h00, "R1");
    check_rd(8'h05, 8'h8F, "R1");
    check_bit(ir_led, 1'b0, "R1");

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      color_mode = VEC[i][28];
      write_reg(VEC[i][27:20], VEC[i][19:12]);
      check_rd(VEC[i][27:20], VEC[i][11:4], $sformatf("R%0d vec%0d", VEC[i][3:0], i));
    end

    // R9 persistence and R4/R6 ignored compat writes
    @(negedge clk); color_mode = 1'b1;
    check_rd(8'h04, 8'h96, "R9");
    check_rd(8'h01, 8'hFE, "R4");
    check_rd(8'h02, 8'h5A, "R9");

    // R2 LED and enable field
    write_reg(8'h00, 8'h01);
    check_bit(ir_led, 1'b1, "R2");
    check_rd(8'h00, 8'h3F, "R2");
    // R3 receive bit forced high with partial enable
    ir_rx = 1'b0;
    write_reg(8'h00, 8'h41);
    repeat (3) @(negedge clk);
    check_rd(8'h00, 8'h7F, "R3");
    // R3 full enable, two-edge latency
    ir_rx = 1'b1;
    write_reg(8'h00, 8'hC1);
    repeat (2) @(negedge clk);
    check_rd(8'h00, 8'hFF, "R3");
    ir_rx = 1'b0;
    @(negedge clk);
    check_rd(8'h00, 8'hFF, "R3 one edge");
    @(negedge clk);
    check_rd(8'h00, 8'hFD, "R3 two edges");
    write_reg(8'h00, 8'h00);
    check_bit(ir_led, 1'b0, "R2");
    check_rd(8'h00, 8'h3E, "R2");

    // R8 amplitude mirrors
    amp1 = 4'h3; amp2 = 4'hA; amp3 = 4'hF; amp4 = 4'h0;
    check_rd(8'h06, 8'hA3, "R8");
    check_rd(8'h07, 8'h0F, "R8");
    write_reg(8'h06, 8'h55);
    check_rd(8'h06, 8'hA3, "R8");

    // R10 unmapped
    write_reg(8'h20, 8'h00);
    check_rd(8'h20, 8'hFF, "R10");
    check_rd(8'hFF, 8'hFF, "R10");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule